// File: doc/BRIEF.md
# Byte FIFO Pair with Trigger-Level Interrupts

This block holds the data staging for a serial controller: one 64-byte queue carries bytes from the host to the serial engine (transmit) and a second carries bytes from the serial engine to the host (receive). The host reaches the block through a word-wide register port. Writing the transmit data register appends a byte, and reading the receive data register removes one. The serial engine pops transmit bytes and pushes receive bytes through strobes of its own.

Each queue has a programmable trigger level. The transmit side raises a request while it is drained down to its trigger. The receive side raises one while it is filled up to its trigger. An idle timer catches a short tail of received bytes that would never reach the receive trigger. Overruns and underruns on both queues are caught. Every cause sits as a sticky bit in an interrupt status register that is cleared by writing ones. An enable mask reduces these bits to a single interrupt line. A transfer-event strobe from the protocol engine shares the same status register.

Top module: `sfifo_irq_ctrl`

## Requirements
- R1: Register word addresses are 0 control, 1 idle limit, 2 interrupt enable, 3 interrupt status, 4 queue status, 5 transmit data (write), 6 receive data (read); other addresses read zero. After reset, control, enable and status are zero, the idle limit is 15, and the interrupt output is low.
- R2: Each queue holds 64 bytes and returns them in first-in first-out order. Its fill level counts 0 to 64.
- R3: The queue status word holds the transmit level in bits [6:0], transmit full in bit 7, transmit empty in bit 8, the receive level in [22:16], receive full in bit 23 and receive empty in bit 24.
- R4: The control word holds receive enable in bit 0, transmit enable in bit 1, a 7-bit receive trigger in [10:4] and a 7-bit transmit trigger in [22:16]. Unused bits read zero.
- R5: Status bit 0 (transmit almost-empty) is set on each cycle in which transmit is enabled and its level is at or below the transmit trigger.
- R6: Status bit 1 (receive almost-full) is set on each cycle in which receive is enabled and its level is at or above the receive trigger.
- R7: A push into a full queue drops the byte. It sets status bit 3 for transmit (host write) or bit 5 for receive (serial push).
- R8: A pop from an empty queue returns zero. It sets status bit 2 for transmit (serial pop) or bit 4 for receive (host read).
- R9: While receive is enabled and holds between 1 and trigger-minus-one bytes, an idle counter advances on every cycle with no receive push. When it reaches the idle limit, status bit 6 (trailing) is set. A push, an empty queue or a level at or above the trigger restarts the counter.
- R10: While a queue's enable bit is clear, the queue is emptied on the next edge, and its push and pop strobes are ignored without setting any status bit.
- R11: Status bits are sticky. Writing ones to the status register clears those bits, except that a cause present in the same cycle sets the bit again. Only bits 0 to 6 and 9 exist.
- R12: The interrupt output is high exactly when some status bit is set whose enable bit (same position) is set.
- R13: A transfer-event strobe sets status bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_rd_i | input | 1 | Host register read strobe (pops receive data) |
| reg_addr_i | input | 3 | Host register word address |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Host read data, combinational from the address |
| rx_push_i | input | 1 | Serial side pushes a received byte |
| rx_byte_i | input | 8 | Received byte |
| tx_pop_i | input | 1 | Serial side takes a transmit byte |
| tx_byte_o | output | 8 | Head of the transmit queue, zero when empty |
| xfer_evt_i | input | 1 | Transfer event strobe from the protocol engine |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after the full-to-one-more and empty-to-one-more edges. A design with an off-by-one there would take a 65th byte or fail to flag the drop, and on an empty pop it would hand out stale data. It also exercises pushes and pops in the same cycle at full and at empty, where the outcome must depend on the level before the edge. For the idle timer, the bench checks the exact cycle it fires and that a fresh push restarts it; a timer that never restarted would fire early, and one that ignored the trigger would fire on a queue that has already raised almost-full. A long mixed random phase also covers clear-versus-set collisions and queues that are disabled with data in them, which a design with a weak flush would leak into the next session.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int DW     = 8;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;
  localparam int TRIG_W = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_TRAIL = 3'd1,
    A_IEN   = 3'd2,
    A_ISTAT = 3'd3,
    A_FSTAT = 3'd4,
    A_TXD   = 3'd5,
    A_RXD   = 3'd6
  } reg_addr_e;

  // interrupt cause positions
  localparam int IB_TX_AE  = 0;
  localparam int IB_RX_AF  = 1;
  localparam int IB_TX_UDF = 2;
  localparam int IB_TX_OVF = 3;
  localparam int IB_RX_UDF = 4;
  localparam int IB_RX_OVF = 5;
  localparam int IB_TRAIL  = 6;
  localparam int IB_XFER   = 9;
  localparam logic [REG_W-1:0] IRQ_MASK = 32'h0000_027F;

  // control word
  localparam int CB_RX_EN   = 0;
  localparam int CB_TX_EN   = 1;
  localparam int CB_RX_TRIG = 4;
  localparam int CB_TX_TRIG = 16;
  localparam logic [REG_W-1:0] CTRL_MASK = 32'h007F_07F3;

  // queue status word
  localparam int SB_TX_LVL   = 0;
  localparam int SB_TX_FULL  = 7;
  localparam int SB_TX_EMPTY = 8;
  localparam int SB_RX_LVL   = 16;
  localparam int SB_RX_FULL  = 23;
  localparam int SB_RX_EMPTY = 24;
endpackage

// File: rtl/sfifo_byte_q.sv
module sfifo_byte_q #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o,
  output logic          udf_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign ovf_o   = push_i && full_o;
  assign udf_o   = pop_i && empty_o;
  assign level_o = cnt_q;
  assign data_o  = empty_o ? '0 : mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= nxt_ptr(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= nxt_ptr(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sfifo_idle_timer.sv
module sfifo_idle_timer #(
  parameter int CW = 8,
  parameter int LW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [LW-1:0] level_i,
  input  logic [LW-1:0] trig_i,
  input  logic          push_i,
  input  logic [CW-1:0] limit_i,
  output logic          fire_o
);
  logic [CW-1:0] cnt_q;
  logic          idle;

  // waiting bytes below the trigger with no fresh arrival
  assign idle   = en_i && (level_i != '0) && (level_i < trig_i) && !push_i;
  assign fire_o = idle && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!idle)             cnt_q <= '0;
    else if (cnt_q != limit_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sfifo_irq_regs.sv
module sfifo_irq_regs #(
  parameter int               W    = 32,
  parameter logic [W-1:0]     MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic         en_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  logic [W-1:0] stat_q, en_q, clr_bits;

  assign clr_bits = clr_wr_i ? wdata_i : '0;
  assign stat_o   = stat_q;
  assign en_o     = en_q;
  assign irq_o    = |(stat_q & en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      // new causes win over a simultaneous clear
      stat_q <= ((stat_q & ~clr_bits) | set_i) & MASK;
      if (en_wr_i) en_q <= wdata_i & MASK;
    end
  end
endmodule

// File: rtl/sfifo_irq_ctrl.sv
module sfifo_irq_ctrl
  import sfifo_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int TRAIL_W   = 8,
  parameter int TRAIL_RST = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              rx_push_i,
  input  logic [DW-1:0]     rx_byte_i,
  input  logic              tx_pop_i,
  output logic [DW-1:0]     tx_byte_o,
  input  logic              xfer_evt_i,
  output logic              irq_o
);
  localparam int LW = $clog2(DEPTH + 1);

  logic [REG_W-1:0]   ctrl_q;
  logic [TRAIL_W-1:0] trail_q;
  logic               tx_en, rx_en;
  logic [TRIG_W-1:0]  tx_trig_f, rx_trig_f;
  logic [LW-1:0]      tx_trig, rx_trig;
  logic [LW-1:0]      tx_lvl, rx_lvl;
  logic               tx_full, tx_empty, rx_full, rx_empty;
  logic               tx_ovf, tx_udf, rx_ovf, rx_udf;
  logic [DW-1:0]      tx_head, rx_head;
  logic               tx_push, rx_pop, trail_fire;
  logic [REG_W-1:0]   set_vec, istat, ien, fstat;

  assign tx_en     = ctrl_q[CB_TX_EN];
  assign rx_en     = ctrl_q[CB_RX_EN];
  assign tx_trig_f = ctrl_q[CB_TX_TRIG +: TRIG_W];
  assign rx_trig_f = ctrl_q[CB_RX_TRIG +: TRIG_W];
  assign tx_trig   = LW'(tx_trig_f);
  assign rx_trig   = LW'(rx_trig_f);

  assign tx_push = tx_en && reg_wr_i && (reg_addr_i == A_TXD);
  assign rx_pop  = rx_en && reg_rd_i && (reg_addr_i == A_RXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      trail_q <= TRAIL_W'(TRAIL_RST);
    end else if (reg_wr_i) begin
      if (reg_addr_i == A_CTRL)  ctrl_q  <= reg_wdata_i & CTRL_MASK;
      if (reg_addr_i == A_TRAIL) trail_q <= reg_wdata_i[TRAIL_W-1:0];
    end
  end

  sfifo_byte_q #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!tx_en),
    .push_i  (tx_push),
    .data_i  (reg_wdata_i[DW-1:0]),
    .pop_i   (tx_en && tx_pop_i),
    .data_o  (tx_head),
    .level_o (tx_lvl),
    .full_o  (tx_full),
    .empty_o (tx_empty),
    .ovf_o   (tx_ovf),
    .udf_o   (tx_udf)
  );

  sfifo_byte_q #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!rx_en),
    .push_i  (rx_en && rx_push_i),
    .data_i  (rx_byte_i),
    .pop_i   (rx_pop),
    .data_o  (rx_head),
    .level_o (rx_lvl),
    .full_o  (rx_full),
    .empty_o (rx_empty),
    .ovf_o   (rx_ovf),
    .udf_o   (rx_udf)
  );

  sfifo_idle_timer #(.CW(TRAIL_W), .LW(LW)) u_trail (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (rx_en),
    .level_i (rx_lvl),
    .trig_i  (rx_trig),
    .push_i  (rx_push_i),
    .limit_i (trail_q),
    .fire_o  (trail_fire)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[IB_TX_AE]  = tx_en && (tx_lvl <= tx_trig);
    set_vec[IB_RX_AF]  = rx_en && (rx_lvl >= rx_trig);
    set_vec[IB_TX_UDF] = tx_udf;
    set_vec[IB_TX_OVF] = tx_ovf;
    set_vec[IB_RX_UDF] = rx_udf;
    set_vec[IB_RX_OVF] = rx_ovf;
    set_vec[IB_TRAIL]  = trail_fire;
    set_vec[IB_XFER]   = xfer_evt_i;
  end

  sfifo_irq_regs #(.W(REG_W), .MASK(IRQ_MASK)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_wr_i (reg_wr_i && (reg_addr_i == A_ISTAT)),
    .en_wr_i  (reg_wr_i && (reg_addr_i == A_IEN)),
    .wdata_i  (reg_wdata_i),
    .stat_o   (istat),
    .en_o     (ien),
    .irq_o    (irq_o)
  );

  always_comb begin
    fstat                        = '0;
    fstat[SB_TX_LVL +: LW]       = tx_lvl;
    fstat[SB_TX_FULL]            = tx_full;
    fstat[SB_TX_EMPTY]           = tx_empty;
    fstat[SB_RX_LVL +: LW]       = rx_lvl;
    fstat[SB_RX_FULL]            = rx_full;
    fstat[SB_RX_EMPTY]           = rx_empty;
  end

  always_comb begin
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o = ctrl_q;
      A_TRAIL: reg_rdata_o = REG_W'(trail_q);
      A_IEN:   reg_rdata_o = ien;
      A_ISTAT: reg_rdata_o = istat;
      A_FSTAT: reg_rdata_o = fstat;
      A_RXD:   reg_rdata_o = rx_en ? REG_W'(rx_head) : '0;
      default: reg_rdata_o = '0;
    endcase
  end

  assign tx_byte_o = tx_en ? tx_head : '0;
endmodule

// File: rtl/sfifo_irq_ctrl_chk.sv
module sfifo_irq_ctrl_chk #(
  parameter int DEPTH = 64,
  parameter int LW    = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_en,
  input logic          rx_en,
  input logic [LW-1:0] tx_lvl,
  input logic [LW-1:0] rx_lvl,
  input logic [LW-1:0] tx_trig,
  input logic          rx_push_i,
  input logic          tx_pop_i,
  input logic [7:0]    tx_byte_o,
  input logic [31:0]   istat,
  input logic          xfer_evt_i,
  input logic          reg_wr_i,
  input logic [2:0]    reg_addr_i,
  input logic [31:0]   reg_wdata_i
);
  p_level_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));

  p_tx_ae_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en && (tx_lvl <= tx_trig) |=> istat[0]);

  p_rx_ovf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en && rx_push_i && (rx_lvl == LW'(DEPTH)) |=> istat[5]);

  p_tx_udf_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_i && (tx_lvl == '0) |-> (tx_byte_o == 8'h00));

  p_tx_udf_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en && tx_pop_i && (tx_lvl == '0) |=> istat[2]);

  p_flush_tx_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en |=> (tx_lvl == '0));

  p_flush_rx_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en |=> (rx_lvl == '0));

  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    istat[3] && !(reg_wr_i && (reg_addr_i == 3'd3) && reg_wdata_i[3]) |=> istat[3]);

  p_xfer_set_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_evt_i |=> istat[9]);
endmodule

bind sfifo_irq_ctrl sfifo_irq_ctrl_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_en       (tx_en),
  .rx_en       (rx_en),
  .tx_lvl      (tx_lvl),
  .rx_lvl      (rx_lvl),
  .tx_trig     (tx_trig),
  .rx_push_i   (rx_push_i),
  .tx_pop_i    (tx_pop_i),
  .tx_byte_o   (tx_byte_o),
  .istat       (istat),
  .xfer_evt_i  (xfer_evt_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i)
);

// File: tb/sfifo_irq_ctrl_bench.sv
module sfifo_irq_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [2:0]  reg_addr_i = 3'd4;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        rx_push_i = 1'b0;
  logic [7:0]  rx_byte_i = '0;
  logic        tx_pop_i = 1'b0;
  logic [7:0]  tx_byte_o;
  logic        xfer_evt_i = 1'b0;
  logic        irq_o;

  always #2 clk_i = ~clk_i;

  sfifo_irq_ctrl u_sfifo_irq_ctrl (.*);

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  // reference model state
  logic [7:0]  q_tx[$], q_rx[$];
  logic [31:0] m_ctrl = '0, m_ien = '0, m_stat = '0;
  int          m_trail = 15, m_tcnt = 0;

  function automatic logic [31:0] exp_rdata();
    logic [31:0] s = '0;
    case (reg_addr_i)
      3'd0: return m_ctrl;
      3'd1: return 32'(m_trail);
      3'd2: return m_ien;
      3'd3: return m_stat;
      3'd4: begin
        s[6:0]   = 7'(q_tx.size());
        s[7]     = q_tx.size() == 64;
        s[8]     = q_tx.size() == 0;
        s[22:16] = 7'(q_rx.size());
        s[23]    = q_rx.size() == 64;
        s[24]    = q_rx.size() == 0;
        return s;
      end
      3'd6: return (m_ctrl[0] && q_rx.size() > 0) ? {24'h0, q_rx[0]} : '0;
      default: return '0;
    endcase
  endfunction

  function automatic void model_step();
    logic [31:0] set = '0;
    bit txe = m_ctrl[1], rxe = m_ctrl[0];
    int rtrig = int'(m_ctrl[10:4]), ttrig = int'(m_ctrl[22:16]);
    int ts = q_tx.size(), rs = q_rx.size();
    bit idle;
    if (xfer_evt_i) set[9] = 1'b1;
    if (txe && ts <= ttrig) set[0] = 1'b1;
    if (rxe && rs >= rtrig) set[1] = 1'b1;
    idle = rxe && rs > 0 && rs < rtrig && !rx_push_i;
    if (idle && m_tcnt == m_trail) set[6] = 1'b1;
    if (!idle) m_tcnt = 0;
    else if (m_tcnt != m_trail) m_tcnt++;
    if (!txe) q_tx.delete();
    else begin
      if (tx_pop_i) begin
        if (ts == 0) set[2] = 1'b1; else void'(q_tx.pop_front());
      end
      if (reg_wr_i && reg_addr_i == 3'd5) begin
        if (ts == 64) set[3] = 1'b1; else q_tx.push_back(reg_wdata_i[7:0]);
      end
    end
    if (!rxe) q_rx.delete();
    else begin
      if (reg_rd_i && reg_addr_i == 3'd6) begin
        if (rs == 0) set[4] = 1'b1; else void'(q_rx.pop_front());
      end
      if (rx_push_i) begin
        if (rs == 64) set[5] = 1'b1; else q_rx.push_back(rx_byte_i);
      end
    end
    m_stat = ((m_stat & ~((reg_wr_i && reg_addr_i == 3'd3) ? reg_wdata_i : 32'h0)) | set)
             & 32'h27F;
    if (reg_wr_i) begin
      if (reg_addr_i == 3'd0) m_ctrl = reg_wdata_i & 32'h007F_07F3;
      if (reg_addr_i == 3'd1) m_trail = int'(reg_wdata_i[7:0]);
      if (reg_addr_i == 3'd2) m_ien = reg_wdata_i & 32'h27F;
    end
  endfunction

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s addr=%0d got=%h exp=%h t=%0t", cur_req, what, reg_addr_i, got, exp, $time);
    end
  endtask

  // one clock: compare outputs mid-cycle, advance model at the edge
  task automatic cyc();
    #1;
    chk("rdata", reg_rdata_o, exp_rdata());
    chk("irq", {31'h0, irq_o}, {31'h0, |(m_stat & m_ien)});
    chk("tx_byte", {24'h0, tx_byte_o}, (m_ctrl[1] && q_tx.size() > 0) ? {24'h0, q_tx[0]} : 32'h0);
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
  endtask

  task automatic idle(input logic [2:0] a = 3'd3);
    reg_wr_i = 0; reg_rd_i = 0; rx_push_i = 0; tx_pop_i = 0; xfer_evt_i = 0;
    reg_addr_i = a;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    idle(a); reg_wr_i = 1; reg_wdata_i = d; cyc(); idle();
  endtask

  task automatic look(input logic [2:0] a);
    idle(a); cyc(); idle();
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: reset values and address map
    cur_req = "R1";
    for (int a = 0; a < 8; a++) look(3'(a));

    // R13 event, R11 clear
    cur_req = "R13";
    idle(); xfer_evt_i = 1; cyc(); idle(); look(3'd3);
    cur_req = "R11";
    wr(3'd3, 32'h200); look(3'd3);
    wr(3'd3, 32'hFFFF_FFFF); look(3'd3);

    // R4/R5: transmit enabled with trigger 16
    cur_req = "R4";
    wr(3'd0, 32'hFFFF_FFFF); look(3'd0);
    wr(3'd0, 32'h0); look(3'd0);
    cur_req = "R5";
    wr(3'd0, (32'd16 << 16) | 32'h2); wait_cyc(2);
    wr(3'd3, 32'h1); look(3'd3);
    cur_req = "R2";
    for (int i = 0; i < 64; i++) wr(3'd5, 32'(i * 3 + 1));
    look(3'd4);
    cur_req = "R5";
    wr(3'd3, 32'h1); look(3'd3);
    cur_req = "R7";
    wr(3'd5, 32'hAA); look(3'd3); look(3'd4);
    cur_req = "R3";
    look(3'd4);
    cur_req = "R2";
    for (int i = 0; i < 64; i++) begin idle(3'd4); tx_pop_i = 1; cyc(); end
    idle(); look(3'd4);
    cur_req = "R8";
    idle(); tx_pop_i = 1; cyc(); idle(); look(3'd3);
    wr(3'd3, 32'hFFF);

    // R9: idle timer on a short receive tail
    cur_req = "R9";
    wr(3'd0, (32'd8 << 4) | 32'h3);
    wr(3'd1, 32'd5);
    for (int i = 0; i < 3; i++) begin idle(); rx_push_i = 1; rx_byte_i = 8'(8'h40 + i); cyc(); end
    idle(); wait_cyc(4);
    idle(); rx_push_i = 1; rx_byte_i = 8'h55; cyc(); idle();
    wait_cyc(10);
    cur_req = "R11";
    wr(3'd3, 32'h40); wait_cyc(2);
    wr(3'd3, 32'h41); look(3'd3);
    cur_req = "R6";
    for (int i = 0; i < 4; i++) begin idle(); rx_push_i = 1; rx_byte_i = 8'(8'h60 + i); cyc(); end
    idle(); wait_cyc(3); look(3'd4);
    cur_req = "R7";
    for (int i = 0; i < 58; i++) begin idle(3'd4); rx_push_i = 1; rx_byte_i = 8'(i); cyc(); end
    idle(); look(3'd4); look(3'd3);
    // simultaneous push and pop while full
    idle(3'd6); rx_push_i = 1; rx_byte_i = 8'hEE; reg_rd_i = 1; cyc(); idle(); look(3'd4); look(3'd3);
    cur_req = "R2";
    for (int i = 0; i < 63; i++) begin idle(3'd6); reg_rd_i = 1; cyc(); end
    cur_req = "R8";
    idle(3'd6); reg_rd_i = 1; cyc(); idle(); look(3'd3);
    idle(3'd6); reg_rd_i = 1; rx_push_i = 1; rx_byte_i = 8'h77; cyc(); idle(); look(3'd6); look(3'd4);

    // R12: enable mask drives the interrupt line
    cur_req = "R12";
    wr(3'd3, 32'hFFF); wr(3'd2, 32'h10); look(3'd3);
    idle(3'd6); reg_rd_i = 1; cyc(); reg_rd_i = 1; cyc(); idle(); wait_cyc(2);
    wr(3'd3, 32'h10); wait_cyc(2);
    wr(3'd2, 32'hFFFF_FFFF); look(3'd2); wait_cyc(2);
    wr(3'd2, 32'h0); wait_cyc(2);

    // R10: disabled receive drops data and ignores strobes
    cur_req = "R10";
    for (int i = 0; i < 5; i++) begin idle(); rx_push_i = 1; rx_byte_i = 8'(8'h90 + i); cyc(); end
    wr(3'd3, 32'hFFF);
    wr(3'd0, 32'h2);
    for (int i = 0; i < 3; i++) begin idle(3'd6); rx_push_i = 1; reg_rd_i = 1; rx_byte_i = 8'h11; cyc(); end
    idle(); look(3'd4); look(3'd3);
    wr(3'd0, (32'd8 << 4) | 32'h3); look(3'd4); look(3'd6);
    wr(3'd0, 32'h0);
    idle(); tx_pop_i = 1; cyc(); idle(); look(3'd3);

    // mixed random traffic across all requirements
    cur_req = "R2";
    wr(3'd0, (32'd20 << 16) | (32'd40 << 4) | 32'h3);
    wr(3'd2, 32'h27F);
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      idle(3'($urandom_range(0, 7)));
      reg_wdata_i = $urandom();
      rx_byte_i   = 8'($urandom());
      rx_push_i   = ($urandom_range(0, 99) < 45);
      tx_pop_i    = ($urandom_range(0, 99) < 45);
      xfer_evt_i  = ($urandom_range(0, 99) < 3);
      if (r < 30) begin reg_addr_i = 3'd5; reg_wr_i = 1; end
      else if (r < 60) begin reg_addr_i = 3'd6; reg_rd_i = 1; end
      else if (r < 63) begin reg_addr_i = 3'd3; reg_wr_i = 1; end
      else if (r < 64) begin
        reg_addr_i = 3'd0; reg_wr_i = 1;
        if ($urandom_range(0, 3) != 0) reg_wdata_i = reg_wdata_i | 32'h3;
      end
      else if (r < 65) begin reg_addr_i = 3'd1; reg_wr_i = 1; reg_wdata_i = 32'($urandom_range(0, 20)); end
      cyc();
    end
    idle(); look(3'd4); look(3'd3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule